// File: doc/BRIEF.md
# Noise Immunity Escalation Controller

This block keeps the receiver's interference-rejection settings: a noise immunity level, a spur immunity level, a first-step detection level and a flag that enables OFDM weak-signal detection. A host raises immunity when OFDM timing errors or CCK timing errors are too frequent, and lowers it when the error rate stays quiet. The host does this by pulsing one of three request strobes. Each request walks a fixed escalation order. Some branches depend on the band in which the rounded beacon signal strength lies: above the high threshold, between the thresholds, or at or below the low threshold. Other branches depend on the channel's capabilities. Usually a request moves a single setting.

The averaged beacon strength enters scaled by a multiplier. Inside the block it is divided back down and rounded half-up before it is compared with the two thresholds. A separate init strobe returns every setting to its starting point. Up and down pulses report each strict level change, so that statistics logic outside the block can count them. Mapping the levels onto radio register values is done elsewhere.

Top module: `nie_ctrl`

## Requirements
- R1: After reset, all three levels are 0, `wsd_on_o` is 1 (1 = weak-signal detection enabled), `busy_o` is 0 and every pulse output is 0.
- R2: A request is accepted on a clock edge when `busy_o` is 0. The block then holds `busy_o` at 1 for exactly one cycle. The settings and pulses update on the following edge. Requests seen while busy are ignored. When several strobes arrive together, init wins over OFDM raise, which wins over CCK raise, which wins over lower.
- R3: On an OFDM raise, noise immunity is incremented if it is below `ni_max_i`. Otherwise spur immunity is incremented if it is below `si_max_i`. Otherwise the band rules of R4 to R6 apply, and only when `rssi_en_i` is 1.
- R4: OFDM raise, high band: if weak-signal detection is on, it is switched off and spur immunity is set to 0. Otherwise the first-step level is incremented if it is below `fs_max_i`.
- R5: OFDM raise, middle band: if weak-signal detection is off, it is switched on. Otherwise the first-step level is incremented if it is below its maximum.
- R6: OFDM raise, low band: this applies only when `cck_chan_i` is 1. Weak-signal detection is switched off if it is on. Otherwise the first-step level is set to 0 if it is above 0. With `cck_chan_i` at 0 nothing changes.
- R7: On a CCK raise, noise immunity is incremented if it is below its maximum. Otherwise, with `rssi_en_i` at 1, the middle and high bands increment the first-step level if it is below its maximum. The low band with `bg_chan_i` at 1 sets the first-step level to 0.
- R8: On a lower request with `rssi_en_i` at 1, the high band changes nothing at the first stage. The middle band switches weak-signal detection on, or failing that decrements the first-step level. The low band decrements the first-step level. If the first stage changed nothing, spur immunity is decremented, or failing that noise immunity is decremented. No level goes below 0.
- R9: The band value is floor(`rssi_avg_i` / MULT), plus 1 when the remainder is at least MULT/2. With MULT = 16, a value of 87 gives 5 and a value of 88 gives 6.
- R10: For each level, the up pulse is high for one cycle exactly when the new level is strictly greater than the old one. The down pulse is high for one cycle exactly when it is strictly smaller. An unchanged level gives no pulse.
- R11: An init request sets all three levels to 0 and switches weak-signal detection on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req_i | input | 1 | Strobe: restore the starting settings |
| ofdm_req_i | input | 1 | Strobe: raise immunity after OFDM errors |
| cck_req_i | input | 1 | Strobe: raise immunity after CCK errors |
| lower_req_i | input | 1 | Strobe: lower immunity |
| rssi_avg_i | input | AVG_W | Averaged beacon strength, scaled by MULT |
| rssi_en_i | input | 1 | Enables the strength-dependent branches |
| cck_chan_i | input | 1 | Channel carries CCK |
| bg_chan_i | input | 1 | Channel is a b or g channel |
| thr_lo_i | input | AVG_W | Low strength threshold |
| thr_hi_i | input | AVG_W | High strength threshold |
| ni_max_i | input | LVL_W | Noise immunity maximum |
| si_max_i | input | LVL_W | Spur immunity maximum |
| fs_max_i | input | LVL_W | First-step maximum |
| busy_o | output | 1 | Update in progress |
| ni_lvl_o | output | LVL_W | Noise immunity level |
| si_lvl_o | output | LVL_W | Spur immunity level |
| fs_lvl_o | output | LVL_W | First-step level |
| wsd_on_o | output | 1 | Weak-signal detection enabled |
| ni_up_o | output | 1 | Noise level rose |
| ni_dn_o | output | 1 | Noise level fell |
| si_up_o | output | 1 | Spur level rose |
| si_dn_o | output | 1 | Spur level fell |
| fs_up_o | output | 1 | First-step level rose |
| fs_dn_o | output | 1 | First-step level fell |

## Verification
Directed sequences first climb noise immunity and then spur immunity to their maxima, which separates the fixed escalation order from the band branches. Beacon values of 87 and 88 sit on either side of the rounding edge, where the choice between the low and middle band flips the outcome of a CCK raise. Strobes issued during the busy cycle, and strobes issued together, distinguish the acceptance rules and the priority among requests. Random sequences then vary the strength, the thresholds, the channel flags, the maxima and the request kind, so that every band branch, every saturation point and the level-0 floor are reached and compared against a bench model.

// File: rtl/nie_pkg.sv
package nie_pkg;
   typedef enum logic [2:0] {
      REQ_NONE  = 3'd0,
      REQ_INIT  = 3'd1,
      REQ_OFDM  = 3'd2,
      REQ_CCK   = 3'd3,
      REQ_LOWER = 3'd4
   } nie_req_e;

   typedef enum logic [1:0] {
      BAND_LOW  = 2'd0,
      BAND_MID  = 2'd1,
      BAND_HIGH = 2'd2
   } nie_band_e;
endpackage

// File: rtl/nie_rssi_band.sv
module nie_rssi_band #(
   parameter int AVG_W = 16,
   parameter int MULT  = 16
) (
   input  logic [AVG_W-1:0]  avg_i,
   input  logic [AVG_W-1:0]  thr_lo_i,
   input  logic [AVG_W-1:0]  thr_hi_i,
   output nie_pkg::nie_band_e band_o
);
   localparam bit POW2   = (MULT & (MULT - 1)) == 0;
   localparam int SH     = $clog2(MULT);
   localparam int HALF   = MULT / 2;

   logic [AVG_W-1:0] quot;
   logic [AVG_W-1:0] rem;
   logic [AVG_W-1:0] rounded;

   if (MULT < 2) begin : g_bad_mult
      $error("nie_rssi_band: MULT must be at least 2");
   end
   if (AVG_W < 2 || AVG_W > 31) begin : g_bad_w
      $error("nie_rssi_band: AVG_W out of range");
   end

   if (POW2) begin : g_shift
      always_comb begin
         quot = avg_i >> SH;
         rem  = avg_i & AVG_W'(MULT - 1);
      end
   end else begin : g_div
      always_comb begin
         quot = avg_i / AVG_W'(MULT);
         rem  = avg_i % AVG_W'(MULT);
      end
   end

   always_comb begin
      rounded = quot + ((rem >= AVG_W'(HALF)) ? AVG_W'(1) : AVG_W'(0));
      if (rounded > thr_hi_i)      band_o = nie_pkg::BAND_HIGH;
      else if (rounded > thr_lo_i) band_o = nie_pkg::BAND_MID;
      else                         band_o = nie_pkg::BAND_LOW;
   end
endmodule

// File: rtl/nie_step_logic.sv
module nie_step_logic #(
   parameter int LVL_W = 3
) (
   input  nie_pkg::nie_req_e  req_i,
   input  nie_pkg::nie_band_e band_i,
   input  logic               rssi_en_i,
   input  logic               cck_chan_i,
   input  logic               bg_chan_i,
   input  logic [LVL_W-1:0]   ni_i,
   input  logic [LVL_W-1:0]   si_i,
   input  logic [LVL_W-1:0]   fs_i,
   input  logic               wsd_i,
   input  logic [LVL_W-1:0]   ni_max_i,
   input  logic [LVL_W-1:0]   si_max_i,
   input  logic [LVL_W-1:0]   fs_max_i,
   output logic [LVL_W-1:0]   ni_o,
   output logic [LVL_W-1:0]   si_o,
   output logic [LVL_W-1:0]   fs_o,
   output logic               wsd_o
);
   import nie_pkg::*;

   localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

   logic first_stage_hit;

   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("nie_step_logic: LVL_W out of range");
   end

   always_comb begin
      ni_o            = ni_i;
      si_o            = si_i;
      fs_o            = fs_i;
      wsd_o           = wsd_i;
      first_stage_hit = 1'b0;
      case (req_i)
         REQ_INIT: begin
            ni_o  = '0;
            si_o  = '0;
            fs_o  = '0;
            wsd_o = 1'b1;
         end
         REQ_OFDM: begin
            if (ni_i < ni_max_i) begin
               ni_o = ni_i + ONE;
            end else if (si_i < si_max_i) begin
               si_o = si_i + ONE;
            end else if (rssi_en_i) begin
               case (band_i)
                  BAND_HIGH: begin
                     if (wsd_i) begin
                        wsd_o = 1'b0;
                        si_o  = '0;
                     end else if (fs_i < fs_max_i) begin
                        fs_o = fs_i + ONE;
                     end
                  end
                  BAND_MID: begin
                     if (!wsd_i)                 wsd_o = 1'b1;
                     else if (fs_i < fs_max_i)   fs_o  = fs_i + ONE;
                  end
                  default: begin
                     if (cck_chan_i) begin
                        if (wsd_i)              wsd_o = 1'b0;
                        else if (fs_i != '0)    fs_o  = '0;
                     end
                  end
               endcase
            end
         end
         REQ_CCK: begin
            if (ni_i < ni_max_i) begin
               ni_o = ni_i + ONE;
            end else if (rssi_en_i) begin
               if (band_i != BAND_LOW) begin
                  if (fs_i < fs_max_i) fs_o = fs_i + ONE;
               end else if (bg_chan_i && (fs_i != '0)) begin
                  fs_o = '0;
               end
            end
         end
         REQ_LOWER: begin
            if (rssi_en_i) begin
               case (band_i)
                  BAND_MID: begin
                     if (!wsd_i) begin
                        wsd_o           = 1'b1;
                        first_stage_hit = 1'b1;
                     end else if (fs_i != '0) begin
                        fs_o            = fs_i - ONE;
                        first_stage_hit = 1'b1;
                     end
                  end
                  BAND_LOW: begin
                     if (fs_i != '0) begin
                        fs_o            = fs_i - ONE;
                        first_stage_hit = 1'b1;
                     end
                  end
                  default: first_stage_hit = 1'b0;
               endcase
            end
            if (!first_stage_hit) begin
               if (si_i != '0)      si_o = si_i - ONE;
               else if (ni_i != '0) ni_o = ni_i - ONE;
            end
         end
         default: ;
      endcase
   end

   // R8: a lower request never raises any level
   always_comb begin
      if (req_i == REQ_LOWER) begin
         a_lower_no_rise_r8: assert (ni_o <= ni_i && si_o <= si_i && fs_o <= fs_i)
            else $error("lower request raised a level");
      end
   end
endmodule

// File: rtl/nie_stat_pulse.sv
module nie_stat_pulse #(
   parameter int LVL_W = 3,
   parameter int N     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit_i,
   input  logic [N*LVL_W-1:0] old_i,
   input  logic [N*LVL_W-1:0] new_i,
   output logic [N-1:0]       up_o,
   output logic [N-1:0]       dn_o
);
   if (N < 1) begin : g_bad_n
      $error("nie_stat_pulse: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_lvl
      logic [LVL_W-1:0] o_v;
      logic [LVL_W-1:0] n_v;
      assign o_v = old_i[i*LVL_W +: LVL_W];
      assign n_v = new_i[i*LVL_W +: LVL_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            up_o[i] <= 1'b0;
            dn_o[i] <= 1'b0;
         end else begin
            up_o[i] <= commit_i && (n_v > o_v);
            dn_o[i] <= commit_i && (n_v < o_v);
         end
      end

      p_up_dn_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !(up_o[i] && dn_o[i]));
      p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (up_o[i] || dn_o[i]) |=> !(up_o[i] || dn_o[i]));
   end

   p_one_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(up_o));
endmodule

// File: rtl/nie_ctrl.sv
module nie_ctrl #(
   parameter int AVG_W = 16,
   parameter int MULT  = 16,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_req_i,
   input  logic             ofdm_req_i,
   input  logic             cck_req_i,
   input  logic             lower_req_i,
   input  logic [AVG_W-1:0] rssi_avg_i,
   input  logic             rssi_en_i,
   input  logic             cck_chan_i,
   input  logic             bg_chan_i,
   input  logic [AVG_W-1:0] thr_lo_i,
   input  logic [AVG_W-1:0] thr_hi_i,
   input  logic [LVL_W-1:0] ni_max_i,
   input  logic [LVL_W-1:0] si_max_i,
   input  logic [LVL_W-1:0] fs_max_i,
   output logic             busy_o,
   output logic [LVL_W-1:0] ni_lvl_o,
   output logic [LVL_W-1:0] si_lvl_o,
   output logic [LVL_W-1:0] fs_lvl_o,
   output logic             wsd_on_o,
   output logic             ni_up_o,
   output logic             ni_dn_o,
   output logic             si_up_o,
   output logic             si_dn_o,
   output logic             fs_up_o,
   output logic             fs_dn_o
);
   import nie_pkg::*;

   localparam int NLVL = 3;

   nie_req_e         req_q;
   nie_req_e         req_sel;
   logic             any_req;
   logic             busy_q;
   nie_band_e        band;
   logic [LVL_W-1:0] ni_q, si_q, fs_q;
   logic             wsd_q;
   logic [LVL_W-1:0] ni_n, si_n, fs_n;
   logic             wsd_n;
   logic [NLVL-1:0]  up_p, dn_p;

   always_comb begin
      any_req = init_req_i | ofdm_req_i | cck_req_i | lower_req_i;
      if (init_req_i)      req_sel = REQ_INIT;
      else if (ofdm_req_i) req_sel = REQ_OFDM;
      else if (cck_req_i)  req_sel = REQ_CCK;
      else if (lower_req_i) req_sel = REQ_LOWER;
      else                 req_sel = REQ_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= REQ_NONE;
         busy_q <= 1'b0;
      end else if (busy_q) begin
         req_q  <= REQ_NONE;
         busy_q <= 1'b0;
      end else if (any_req) begin
         req_q  <= req_sel;
         busy_q <= 1'b1;
      end
   end

   nie_rssi_band #(.AVG_W(AVG_W), .MULT(MULT)) u_band (
      .avg_i    (rssi_avg_i),
      .thr_lo_i (thr_lo_i),
      .thr_hi_i (thr_hi_i),
      .band_o   (band)
   );

   nie_step_logic #(.LVL_W(LVL_W)) u_step (
      .req_i      (req_q),
      .band_i     (band),
      .rssi_en_i  (rssi_en_i),
      .cck_chan_i (cck_chan_i),
      .bg_chan_i  (bg_chan_i),
      .ni_i       (ni_q),
      .si_i       (si_q),
      .fs_i       (fs_q),
      .wsd_i      (wsd_q),
      .ni_max_i   (ni_max_i),
      .si_max_i   (si_max_i),
      .fs_max_i   (fs_max_i),
      .ni_o       (ni_n),
      .si_o       (si_n),
      .fs_o       (fs_n),
      .wsd_o      (wsd_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ni_q  <= '0;
         si_q  <= '0;
         fs_q  <= '0;
         wsd_q <= 1'b1;
      end else if (busy_q) begin
         ni_q  <= ni_n;
         si_q  <= si_n;
         fs_q  <= fs_n;
         wsd_q <= wsd_n;
      end
   end

   nie_stat_pulse #(.LVL_W(LVL_W), .N(NLVL)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (busy_q),
      .old_i    ({fs_q, si_q, ni_q}),
      .new_i    ({fs_n, si_n, ni_n}),
      .up_o     (up_p),
      .dn_o     (dn_p)
   );

   assign busy_o   = busy_q;
   assign ni_lvl_o = ni_q;
   assign si_lvl_o = si_q;
   assign fs_lvl_o = fs_q;
   assign wsd_on_o = wsd_q;
   assign ni_up_o  = up_p[0];
   assign si_up_o  = up_p[1];
   assign fs_up_o  = up_p[2];
   assign ni_dn_o  = dn_p[0];
   assign si_dn_o  = dn_p[1];
   assign fs_dn_o  = dn_p[2];

   p_busy_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> $stable({ni_q, si_q, fs_q, wsd_q}));
   p_fs_up_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fs_up_o |-> (fs_q == $past(fs_q) + LVL_W'(1)));
   p_ni_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ni_up_o |-> (ni_q == $past(ni_q) + LVL_W'(1)));
   p_ni_dn_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ni_dn_o |-> (ni_q < $past(ni_q)));
endmodule

// File: tb/nie_ctrl_tb.sv
module nie_ctrl_tb;
   localparam int AVG_W = 16;
   localparam int MULT  = 16;
   localparam int LVL_W = 3;
   localparam int WD_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_req = 0, ofdm_req = 0, cck_req = 0, lower_req = 0;
   logic [AVG_W-1:0] rssi_avg = '0;
   logic rssi_en = 0, cck_chan = 0, bg_chan = 0;
   logic [AVG_W-1:0] thr_lo = '0, thr_hi = '0;
   logic [LVL_W-1:0] ni_max = '0, si_max = '0, fs_max = '0;
   logic busy, wsd_on;
   logic [LVL_W-1:0] ni_lvl, si_lvl, fs_lvl;
   logic ni_up, ni_dn, si_up, si_dn, fs_up, fs_dn;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   bit finished = 0;
   int m_ni = 0, m_si = 0, m_fs = 0, m_wsd = 1;

   always #10 clk = ~clk;

   nie_ctrl #(.AVG_W(AVG_W), .MULT(MULT), .LVL_W(LVL_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .init_req_i(init_req), .ofdm_req_i(ofdm_req), .cck_req_i(cck_req),
      .lower_req_i(lower_req), .rssi_avg_i(rssi_avg), .rssi_en_i(rssi_en),
      .cck_chan_i(cck_chan), .bg_chan_i(bg_chan), .thr_lo_i(thr_lo),
      .thr_hi_i(thr_hi), .ni_max_i(ni_max), .si_max_i(si_max), .fs_max_i(fs_max),
      .busy_o(busy), .ni_lvl_o(ni_lvl), .si_lvl_o(si_lvl), .fs_lvl_o(fs_lvl),
      .wsd_on_o(wsd_on), .ni_up_o(ni_up), .ni_dn_o(ni_dn), .si_up_o(si_up),
      .si_dn_o(si_dn), .fs_up_o(fs_up), .fs_dn_o(fs_dn)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int band_of();
      int r;
      r = (int'(rssi_avg) + MULT / 2) / MULT;
      if (r > int'(thr_hi)) return 2;
      if (r > int'(thr_lo)) return 1;
      return 0;
   endfunction

   // kind: 0 init, 1 ofdm raise, 2 cck raise, 3 lower
   function automatic string tag_of(input int kind);
      if (kind == 0) return "R11";
      if (kind == 2) return "R7";
      if (kind == 3) return "R8";
      if (m_ni < int'(ni_max) || m_si < int'(si_max) || !rssi_en) return "R3";
      if (band_of() == 2) return "R4";
      if (band_of() == 1) return "R5";
      return "R6";
   endfunction

   task automatic model_step(input int kind);
      int b;
      bit hit;
      b = band_of();
      hit = 0;
      if (kind == 0) begin
         m_ni = 0; m_si = 0; m_fs = 0; m_wsd = 1;
      end else if (kind == 1) begin
         if (m_ni < int'(ni_max)) m_ni++;
         else if (m_si < int'(si_max)) m_si++;
         else if (rssi_en) begin
            if (b == 2) begin
               if (m_wsd == 1) begin m_wsd = 0; m_si = 0; end
               else if (m_fs < int'(fs_max)) m_fs++;
            end else if (b == 1) begin
               if (m_wsd == 0) m_wsd = 1;
               else if (m_fs < int'(fs_max)) m_fs++;
            end else if (cck_chan) begin
               if (m_wsd == 1) m_wsd = 0;
               else if (m_fs > 0) m_fs = 0;
            end
         end
      end else if (kind == 2) begin
         if (m_ni < int'(ni_max)) m_ni++;
         else if (rssi_en) begin
            if (b != 0) begin
               if (m_fs < int'(fs_max)) m_fs++;
            end else if (bg_chan && m_fs > 0) m_fs = 0;
         end
      end else begin
         if (rssi_en && b == 1) begin
            if (m_wsd == 0) begin m_wsd = 1; hit = 1; end
            else if (m_fs > 0) begin m_fs--; hit = 1; end
         end else if (rssi_en && b == 0) begin
            if (m_fs > 0) begin m_fs--; hit = 1; end
         end
         if (!hit) begin
            if (m_si > 0) m_si--;
            else if (m_ni > 0) m_ni--;
         end
      end
   endtask

   task automatic check_state(input string tag);
      chk(tag, "noise level", int'(ni_lvl), m_ni);
      chk(tag, "spur level", int'(si_lvl), m_si);
      chk(tag, "first-step level", int'(fs_lvl), m_fs);
      chk(tag, "weak-signal flag", int'(wsd_on), m_wsd);
   endtask

   task automatic set_strobe(input int kind, input logic v);
      case (kind)
         0: init_req = v;
         1: ofdm_req = v;
         2: cck_req = v;
         default: lower_req = v;
      endcase
   endtask

   // drives one request and checks state, pulses and busy timing
   task automatic run_req(input int kind);
      int o_ni, o_si, o_fs;
      string tag;
      o_ni = m_ni; o_si = m_si; o_fs = m_fs;
      tag = tag_of(kind);
      set_strobe(kind, 1'b1);
      @(negedge clk);
      set_strobe(kind, 1'b0);
      chk("R2", "busy after accept", int'(busy), 1);
      @(negedge clk);
      model_step(kind);
      check_state(tag);
      chk("R2", "busy after update", int'(busy), 0);
      chk("R10", "ni up pulse", int'(ni_up), int'(m_ni > o_ni));
      chk("R10", "ni down pulse", int'(ni_dn), int'(m_ni < o_ni));
      chk("R10", "si up pulse", int'(si_up), int'(m_si > o_si));
      chk("R10", "si down pulse", int'(si_dn), int'(m_si < o_si));
      chk("R10", "fs up pulse", int'(fs_up), int'(m_fs > o_fs));
      chk("R10", "fs down pulse", int'(fs_dn), int'(m_fs < o_fs));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !finished) begin
         finished = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      check_state("R1");
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "pulses", int'({ni_up, ni_dn, si_up, si_dn, fs_up, fs_dn}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: climb noise then spur immunity
      ni_max = 3'd2; si_max = 3'd2; fs_max = 3'd3;
      rssi_en = 1; thr_lo = 16'd5; thr_hi = 16'd10; rssi_avg = 16'd200;
      for (int i = 0; i < 4; i++) run_req(1);
      chk("R3", "noise at max", int'(ni_lvl), 2);
      chk("R3", "spur at max", int'(si_lvl), 2);
      // R4: high band turns detection off and clears spur
      run_req(1);
      chk("R4", "detection off", int'(wsd_on), 0);
      chk("R4", "spur cleared", int'(si_lvl), 0);

      // R9: rounding edge, cck raise with noise at max, b/g off
      bg_chan = 0;
      rssi_avg = 16'd87;
      run_req(2);
      chk("R9", "87 rounds into low band", int'(fs_lvl), 0);
      rssi_avg = 16'd88;
      run_req(2);
      chk("R9", "88 rounds into middle band", int'(fs_lvl), 1);

      // R2: request during busy is ignored, priority on simultaneous strobes
      ofdm_req = 1; lower_req = 1;
      @(negedge clk);
      ofdm_req = 0; lower_req = 0; cck_req = 1;
      chk("R2", "busy", int'(busy), 1);
      @(negedge clk);
      cck_req = 0;
      model_step(1);
      check_state("R2");
      @(negedge clk);
      check_state("R2");
      chk("R2", "no second update", int'({ni_up, si_up, fs_up, ni_dn, si_dn, fs_dn}), 0);

      // R11: init after raises
      run_req(0);
      chk("R11", "detection on", int'(wsd_on), 1);

      // R6, R8 directed: low band on CCK channel, then lower steps
      ni_max = 3'd0; si_max = 3'd0; cck_chan = 1; rssi_avg = 16'd16;
      run_req(1);
      chk("R6", "detection off", int'(wsd_on), 0);
      rssi_avg = 16'd100;
      run_req(3);
      chk("R8", "middle band re-enables", int'(wsd_on), 1);

      // random mix
      for (int it = 0; it < 600; it++) begin
         int k;
         rssi_avg = 16'($urandom % 300);
         thr_lo   = 16'(3 + $urandom % 6);
         thr_hi   = thr_lo + 16'(1 + $urandom % 6);
         rssi_en  = ($urandom % 4) != 0;
         cck_chan = $urandom % 2;
         bg_chan  = $urandom % 2;
         ni_max   = 3'($urandom % 8);
         si_max   = 3'($urandom % 8);
         fs_max   = 3'($urandom % 8);
         k = $urandom % 20;
         if (k == 0) run_req(0);
         else if (k < 8) run_req(1);
         else if (k < 12) run_req(2);
         else run_req(3);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule